// File: doc/BRIEF.md
# Serial Master Bus Front-End

This block sits between a Wishbone slave port and a word-oriented serial master engine. Software writes words for transmission into a transmit queue and takes received words out of a receive queue. Both queues sit behind the same bus address. A second address holds a control register, which selects the target slave, and a status register. The engine side is a plain word handshake. The head of the transmit queue is always visible with a valid flag, and the engine pops it with a one-cycle take pulse. Received words are pushed with a one-cycle put pulse. The engine also reports whether it is busy, and signals a data-ready event.

Overruns never stall either side. A word that meets a full queue is dropped. It then raises a sticky flag for that queue, and the flags drive a dedicated overflow interrupt line. Reading status reports the flags and clears them. The data-ready interrupt line is kept separate from the overflow line and follows the engine's event directly.

The queue depth, pointer width, word width and slave-select width are parameters. The pointer width must cover the depth, and the word width must hold the five status bits.

Top module: `spi_bus_front`

## Requirements
- R1: A bus write with address 0 appends the write data to the transmit queue. `eng_tx_valid` is high whenever the queue is non-empty. `eng_tx_data` shows the oldest word. Each `eng_tx_take` pulse removes that word, and the words leave in write order. A take while the queue is empty has no effect.
- R2: A bus read with address 0 returns the oldest received word, valid together with the ack, and removes it from the queue. Reading an empty receive queue returns zero and removes nothing.
- R3: A bus write with address 1 loads the control register. `sel_idx` shows the low SELW bits of the written word. The other bits are discarded.
- R4: A bus read with address 1 returns the status word. Bit 0 is the `eng_busy` input. Bit 1 is 1 when the transmit queue is not full. Bit 2 is 1 when the receive queue is not empty. Bit 3 is the receive overflow flag. Bit 4 is the transmit overflow flag. All higher bits read 0.
- R5: A bus write to address 0 while the transmit queue holds DEPTH words is discarded, and it sets the sticky transmit overflow flag.
- R6: An `eng_rx_put` while the receive queue holds DEPTH words is discarded, and it sets the sticky receive overflow flag.
- R7: `irq_ovf` is high exactly when either overflow flag is set. A status read clears both flags, so `irq_ovf` is low in the cycle after that read unless a new overflow occurs in the same cycle.
- R8: `irq_ready` follows `eng_ready` in the same cycle.
- R9: `bus_ack` rises in the cycle after a strobe is first seen and stays high for exactly one cycle, even while the strobe is held.
- R10: Each queue holds exactly DEPTH words. After DEPTH writes into an empty transmit queue, status bit 1 reads 0.
- R11: After reset both queues are empty, both flags are clear, `sel_idx` is 0 and `bus_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 1 | Register address: 0 selects the queues, 1 selects control and status |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write enable |
| bus_stb | input | 1 | Strobe |
| bus_ack | output | 1 | Acknowledge |
| bus_rdata | output | DW | Read data, valid with the ack |
| eng_tx_data | output | DW | Oldest word in the transmit queue |
| eng_tx_valid | output | 1 | Transmit queue is not empty |
| eng_tx_take | input | 1 | Engine removes the oldest transmit word |
| eng_rx_data | input | DW | Received word from the engine |
| eng_rx_put | input | 1 | Engine delivers a received word |
| eng_busy | input | 1 | Engine is in a transfer |
| eng_ready | input | 1 | Engine data-ready event |
| sel_idx | output | SELW | Slave-select index from the control register |
| irq_ready | output | 1 | Data-ready interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions watch the bus handshake on every cycle: a single-cycle ack that always follows a strobe, and a zero return when a read meets an empty receive queue. They also watch how the overflow flags behave against the queue fill levels: an overrun raises `irq_ovf`, the line stays up until status is read, and it drops once that read completes. Ordering of words through both queues, the status bit layout, discarding on overrun and the slave-select field can only be shown by the bench, which compares each read and each engine-side word against a queue model under mixed random traffic.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

   localparam int ST_BITS = 5;

   // Status layout: bit 0 busy ... bit 4 transmit overflow
   typedef struct packed {
      logic tx_ovf;
      logic rx_ovf;
      logic rx_rdy;
      logic tx_free;
      logic busy;
   } status_t;

endpackage

// File: rtl/spi_front_fifo.sv
module spi_front_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 6,
   parameter int AW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("spi_front_fifo: DEPTH must be 1..2**AW");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign rdata   = mem[rp];

   // pointer wrap: free overflow for power-of-two depth, compare otherwise
   if (DEPTH == (1 << AW)) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_mod
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spi_front_regs.sv
module spi_front_regs
   import spi_front_pkg::*;
#(
   parameter int DW   = 8,
   parameter int SELW = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_ctl,
   input  logic            rd_st,
   input  logic            rd_rx,
   input  logic [DW-1:0]   wdata,
   input  logic [DW-1:0]   rx_head,
   input  logic            rx_empty,
   input  logic            tx_full,
   input  logic            busy,
   input  logic            tx_ovf_ev,
   input  logic            rx_ovf_ev,
   output logic [DW-1:0]   rdata,
   output logic [SELW-1:0] sel_idx,
   output logic            irq_ovf
);
   if (DW < ST_BITS) begin : g_bad_dw
      $error("spi_front_regs: DW must hold the status word");
   end
   if (SELW < 1 || SELW > DW) begin : g_bad_selw
      $error("spi_front_regs: SELW must be 1..DW");
   end

   logic    tx_ovf, rx_ovf;
   status_t st;

   always_comb begin
      st.busy    = busy;
      st.tx_free = !tx_full;
      st.rx_rdy  = !rx_empty;
      st.rx_ovf  = rx_ovf;
      st.tx_ovf  = tx_ovf;
   end

   assign irq_ovf = tx_ovf | rx_ovf;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_idx <= '0;
         tx_ovf  <= 1'b0;
         rx_ovf  <= 1'b0;
         rdata   <= '0;
      end else begin
         if (wr_ctl) sel_idx <= wdata[SELW-1:0];
         // a new overflow wins over the clear of a status read
         tx_ovf <= tx_ovf_ev | (tx_ovf & !rd_st);
         rx_ovf <= rx_ovf_ev | (rx_ovf & !rd_st);
         if (rd_st)      rdata <= DW'(st);
         else if (rd_rx) rdata <= rx_empty ? '0 : rx_head;
      end
   end
endmodule

// File: rtl/spi_bus_front.sv
module spi_bus_front #(
   parameter int DW    = 8,
   parameter int DEPTH = 6,
   parameter int AW    = 3,
   parameter int SELW  = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   input  logic            bus_we,
   input  logic            bus_stb,
   output logic            bus_ack,
   output logic [DW-1:0]   bus_rdata,
   output logic [DW-1:0]   eng_tx_data,
   output logic            eng_tx_valid,
   input  logic            eng_tx_take,
   input  logic [DW-1:0]   eng_rx_data,
   input  logic            eng_rx_put,
   input  logic            eng_busy,
   input  logic            eng_ready,
   output logic [SELW-1:0] sel_idx,
   output logic            irq_ready,
   output logic            irq_ovf
);
   logic          accept, wr_tx, rd_rx, wr_ctl, rd_st;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic [DW-1:0] rx_head;

   assign accept = bus_stb && !bus_ack;
   assign wr_tx  = accept &&  bus_we && !bus_addr;
   assign rd_rx  = accept && !bus_we && !bus_addr;
   assign wr_ctl = accept &&  bus_we &&  bus_addr;
   assign rd_st  = accept && !bus_we &&  bus_addr;

   always_ff @(posedge clk) begin
      if (rst) bus_ack <= 1'b0;
      else     bus_ack <= accept;
   end

   spi_front_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_txq (
      .clk   (clk),
      .rst   (rst),
      .push  (wr_tx),
      .pop   (eng_tx_take),
      .wdata (bus_wdata),
      .rdata (eng_tx_data),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spi_front_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rxq (
      .clk   (clk),
      .rst   (rst),
      .push  (eng_rx_put),
      .pop   (rd_rx),
      .wdata (eng_rx_data),
      .rdata (rx_head),
      .full  (rx_full),
      .empty (rx_empty)
   );

   spi_front_regs #(.DW(DW), .SELW(SELW)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_ctl    (wr_ctl),
      .rd_st     (rd_st),
      .rd_rx     (rd_rx),
      .wdata     (bus_wdata),
      .rx_head   (rx_head),
      .rx_empty  (rx_empty),
      .tx_full   (tx_full),
      .busy      (eng_busy),
      .tx_ovf_ev (wr_tx && tx_full),
      .rx_ovf_ev (eng_rx_put && rx_full),
      .rdata     (bus_rdata),
      .sel_idx   (sel_idx),
      .irq_ovf   (irq_ovf)
   );

   assign eng_tx_valid = !tx_empty;
   assign irq_ready    = eng_ready;
endmodule

// File: rtl/spi_bus_front_chk.sv
module spi_bus_front_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          bus_addr,
   input logic          bus_we,
   input logic          bus_stb,
   input logic          bus_ack,
   input logic [DW-1:0] bus_rdata,
   input logic          eng_rx_put,
   input logic          irq_ovf,
   input logic          tx_full,
   input logic          rx_full,
   input logic          rx_empty
);
   logic acc;
   assign acc = bus_stb && !bus_ack;

   a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
      bus_ack |=> !bus_ack);

   a_r9_ack_after_stb: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_ack) |-> $past(bus_stb));

   a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
      (acc && !bus_we && !bus_addr && rx_empty) |=> (bus_rdata == '0));

   a_r5_tx_overflow_irq: assert property (@(posedge clk) disable iff (rst)
      (acc && bus_we && !bus_addr && tx_full) |=> irq_ovf);

   a_r6_rx_overflow_irq: assert property (@(posedge clk) disable iff (rst)
      (eng_rx_put && rx_full) |=> irq_ovf);

   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      (irq_ovf && !(acc && !bus_we && bus_addr)) |=> irq_ovf);

   a_r7_ovf_cleared: assert property (@(posedge clk) disable iff (rst)
      (acc && !bus_we && bus_addr && !eng_rx_put) |=> !irq_ovf);
endmodule

bind spi_bus_front spi_bus_front_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .bus_stb    (bus_stb),
   .bus_ack    (bus_ack),
   .bus_rdata  (bus_rdata),
   .eng_rx_put (eng_rx_put),
   .irq_ovf    (irq_ovf),
   .tx_full    (tx_full),
   .rx_full    (rx_full),
   .rx_empty   (rx_empty)
);

// File: tb/spi_bus_front_bench.sv
`timescale 1ns/1ps
module spi_bus_front_bench;
   localparam int DW = 8, D = 6, AW = 3, SELW = 1;

   logic          clk = 1'b0, rst = 1'b1;
   logic          bus_addr = 1'b0, bus_we = 1'b0, bus_stb = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_ack;
   logic [DW-1:0] bus_rdata, eng_tx_data;
   logic          eng_tx_valid, eng_tx_take = 1'b0, eng_rx_put = 1'b0;
   logic [DW-1:0] eng_rx_data = '0;
   logic          eng_busy = 1'b0, eng_ready = 1'b0;
   logic [SELW-1:0] sel_idx;
   logic          irq_ready, irq_ovf;

   int errors = 0, checks = 0;
   bit done = 0;

   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];
   bit m_txo = 0, m_rxo = 0;
   logic [SELW-1:0] m_sel = '0;

   always #10 clk = ~clk;

   spi_bus_front #(.DW(DW), .DEPTH(D), .AW(AW), .SELW(SELW)) u_spi_bus_front (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_stb(bus_stb), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .eng_tx_data(eng_tx_data),
      .eng_tx_valid(eng_tx_valid), .eng_tx_take(eng_tx_take),
      .eng_rx_data(eng_rx_data), .eng_rx_put(eng_rx_put),
      .eng_busy(eng_busy), .eng_ready(eng_ready), .sel_idx(sel_idx),
      .irq_ready(irq_ready), .irq_ovf(irq_ovf));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_status();
      return DW'({m_txo, m_rxo, rxq.size() != 0, txq.size() != D, eng_busy});
   endfunction

   task automatic check_irq();
      check(irq_ovf == (m_txo | m_rxo), "R7 irq_ovf", irq_ovf, m_txo | m_rxo);
   endtask

   // one bus transfer; strobe for one cycle, ack and data checked after it
   task automatic bus_op(input bit we, input bit addr, input logic [DW-1:0] wd,
                         input logic [DW-1:0] exp, input string req);
      @(negedge clk);
      bus_stb = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
      @(negedge clk);
      check(bus_ack == 1'b1, "R9 ack", bus_ack, 1);
      if (!we) check(bus_rdata == exp, req, bus_rdata, exp);
      bus_stb = 1'b0;
      @(negedge clk);
      check(bus_ack == 1'b0, "R9 ack low", bus_ack, 0);
   endtask

   task automatic wr_tx(input logic [DW-1:0] d);
      if (txq.size() == D) m_txo = 1; else txq.push_back(d);
      bus_op(1, 0, d, '0, "R1");
      check_irq();
   endtask

   task automatic rd_rx();
      logic [DW-1:0] e;
      e = (rxq.size() != 0) ? rxq.pop_front() : '0;
      bus_op(0, 0, '0, e, "R2 rx read");
   endtask

   task automatic rd_st();
      logic [DW-1:0] e;
      e = exp_status();
      bus_op(0, 1, '0, e, "R4 status");
      m_txo = 0; m_rxo = 0;
      check_irq();
   endtask

   task automatic wr_ctl(input logic [DW-1:0] d);
      m_sel = d[SELW-1:0];
      bus_op(1, 1, d, '0, "R3");
      check(sel_idx == m_sel, "R3 sel_idx", sel_idx, m_sel);
   endtask

   task automatic eng_put(input logic [DW-1:0] d);
      @(negedge clk);
      eng_rx_put = 1'b1; eng_rx_data = d;
      if (rxq.size() == D) m_rxo = 1; else rxq.push_back(d);
      @(negedge clk);
      eng_rx_put = 1'b0;
      check_irq();
   endtask

   task automatic eng_take();
      @(negedge clk);
      check(eng_tx_valid == (txq.size() != 0), "R1 valid", eng_tx_valid, txq.size() != 0);
      if (txq.size() != 0)
         check(eng_tx_data == txq[0], "R1 order", eng_tx_data, txq[0]);
      eng_tx_take = 1'b1;
      @(negedge clk);
      eng_tx_take = 1'b0;
      if (txq.size() != 0) void'(txq.pop_front());
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 reset state
      check(bus_ack == 0, "R11 ack", bus_ack, 0);
      check(eng_tx_valid == 0, "R11 tx empty", eng_tx_valid, 0);
      check(irq_ovf == 0, "R11 flags", irq_ovf, 0);
      check(sel_idx == 0, "R11 sel", sel_idx, 0);
      rd_st();

      // R10 capacity and R5 transmit overflow
      for (int i = 0; i < D; i++) wr_tx(DW'(8'h10 + i));
      begin
         logic [DW-1:0] s;
         s = exp_status();
         check(s[1] == 1'b0, "R10 tx full after DEPTH", s[1], 0);
      end
      wr_tx(8'hEE);
      check(irq_ovf == 1, "R5 tx overflow", irq_ovf, 1);
      rd_st();
      check(irq_ovf == 0, "R7 cleared", irq_ovf, 0);
      for (int i = 0; i < D + 1; i++) eng_take();

      // R6 receive overflow and R2 empty read
      for (int i = 0; i < D + 1; i++) eng_put(DW'(8'hA0 + i));
      check(irq_ovf == 1, "R6 rx overflow", irq_ovf, 1);
      rd_st();
      for (int i = 0; i < D + 1; i++) rd_rx();

      // R3 control
      wr_ctl(8'hFF);
      wr_ctl(8'hFE);
      wr_ctl(8'h03);

      // R8 and R4 busy bit
      @(negedge clk);
      eng_ready = 1'b1;
      #1 check(irq_ready == 1, "R8 ready high", irq_ready, 1);
      eng_ready = 1'b0;
      #1 check(irq_ready == 0, "R8 ready low", irq_ready, 0);
      eng_busy = 1'b1;
      rd_st();
      eng_busy = 1'b0;

      // R9 held strobe
      @(negedge clk);
      bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = '0;
      @(negedge clk);
      check(bus_ack == 1, "R9 held first", bus_ack, 1);
      @(negedge clk);
      check(bus_ack == 0, "R9 held single", bus_ack, 0);
      bus_stb = 1'b0;
      m_sel = '0;
      @(negedge clk);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int unsigned op;
         op = $urandom_range(0, 5);
         eng_busy = 1'($urandom);
         case (op)
            0, 1: wr_tx(DW'($urandom));
            2:    eng_take();
            3:    eng_put(DW'($urandom));
            4:    rd_rx();
            default: if ($urandom_range(0, 3) == 0) wr_ctl(DW'($urandom)); else rd_st();
         endcase
      end
      eng_busy = 1'b0;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule